// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Segment Driver

This block is a synchronous model of a 40-channel segment driver for a dot-matrix liquid-crystal panel. Display data arrives serially on two independent 20-stage shift chains. Each chain has its own serial input and serial output. Both chains advance on the falling edge of a slow shift clock.

A level-sensitive latch enable copies the 40 chain bits into a display latch. Each latched bit is then combined with a frame-alternation input. The result is a 2-bit rail-select code per channel, which picks one of four drive rails. Analog rail switching is outside the block.

The block runs on a fast system clock. The shift clock, latch enable, alternation input and both serial data inputs are asynchronous slow signals. Each of them is brought into the system clock domain through a two-flop synchronizer.

The serial outputs allow devices to be chained:
- Tying the first chain's output to the second chain's input forms one 40-stage chain.
- Tying the second chain's output to the first input of another device widens the panel.

Top module: `seg_drive_top`

## Requirements
- R1: A synchronous active-high reset clears both chains and the display latch. After reset, both serial outputs read 0 and every channel code reads 2'b01.
- R2: Chain A shifts exactly once per falling edge of `shift_clk_i`. A rising edge does not shift it. `ser_a_o` shows chain A's last stage, so it repeats `ser_a_i` delayed by 20 shifts.
- R3: Chain B behaves the same way as chain A, but on its own input `ser_b_i` and output `ser_b_o`. It runs independently of chain A.
- R4: With `ser_a_o` tied to `ser_b_i`, the two chains form one 40-stage chain. `ser_b_o` then repeats `ser_a_i` delayed by 40 shifts.
- R5: While `latch_en_i` is high, the latch follows the chain contents. Shifts made while it is high appear on `lvl_o`.
- R6: While `latch_en_i` is low, shifting has no effect on `lvl_o`.
- R7: Each channel code is 2 bits, encoding the rail as follows:

  | Code | Rail | Latched data | `alt_i` |
  |------|------|--------------|---------|
  | 00 | VDD | 1 | 0 |
  | 01 | V2 | 0 | 0 |
  | 10 | V3 | 0 | 1 |
  | 11 | VEE | 1 | 1 |

- R8: A change of `alt_i` alone, with the latch enable low, re-codes all channels from the held data.
- R9: Channel k (0-based) sits at bits [2k+1:2k] of `lvl_o`. Channels 0..19 come from chain A stages 0..19, and channels 20..39 come from chain B stages 0..19. Stage 0 holds the most recent bit, so the bit shifted in first lands on channel 19 (or 39) after 20 shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_clk_i | input | 1 | Asynchronous shift clock; chains advance on its falling edge |
| latch_en_i | input | 1 | Asynchronous level-sensitive latch enable |
| alt_i | input | 1 | Asynchronous frame-alternation signal |
| ser_a_i | input | 1 | Serial data into chain A |
| ser_b_i | input | 1 | Serial data into chain B |
| ser_a_o | output | 1 | Last stage of chain A |
| ser_b_o | output | 1 | Last stage of chain B |
| lvl_o | output | 80 | Rail-select codes, 2 bits per channel |

## Verification
The bench goes after the following corner cases:
- **Shift count.** It checks that each shift clock pulse gives exactly one shift. A design that also shifted on the rising edge would shift twice per pulse, and the serial outputs would show the 20-shift delay as 10.
- **Cascade sampling.** With the chains tied together, chain B must take chain A's old last stage at the shared edge. A design that sampled the new value would skip a stage and break the 40-shift delay.
- **Latch hold.** It shifts while the latch is low to catch a latch that leaks chain contents. It shifts while the latch is high to catch one that only captures on the enable edge.
- **Alternation and mapping.** It flips the alternation signal over held data to catch an encoder with swapped rails. A single one walked to the far stage catches a reversed channel order.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    RAIL_VDD = 2'b00,
    RAIL_V2  = 2'b01,
    RAIL_V3  = 2'b10,
    RAIL_VEE = 2'b11
  } rail_e;

  // selected data drives the outer rails, polarity set by the frame signal
  function automatic rail_e pick_rail(input logic dat, input logic alt);
    if (dat) return alt ? RAIL_VEE : RAIL_VDD;
    else     return alt ? RAIL_V3  : RAIL_V2;
  endfunction
endpackage

// File: rtl/segdrv_sync.sv
module segdrv_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe_q[s] <= '0;
        else if (s == 0) pipe_q[s] <= async_i;
        else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/segdrv_fall_det.sv
module segdrv_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_i;
  end

  assign fall_o = prev_q & ~level_i;

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/segdrv_chain.sv
module segdrv_chain #(
  parameter int LEN = 20
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           din,
  output logic [LEN-1:0] stages_o,
  output logic           dout
);
  logic [LEN-1:0] stages_q;

  always_ff @(posedge clk) begin
    if (rst)           stages_q <= '0;
    else if (shift_en) stages_q <= {stages_q[LEN-2:0], din};
  end

  assign stages_o = stages_q;
  assign dout     = stages_q[LEN-1];

  // R2
  chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(stages_q));
  // R2
  chain_step_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (stages_q == {$past(stages_q[LEN-2:0]), $past(din)}));
endmodule

// File: rtl/segdrv_out.sv
module segdrv_out
  import segdrv_pkg::*;
#(
  parameter int NCH = 40,
  localparam int OUT_W = NCH * CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic             alt,
  input  logic [NCH-1:0]   data_i,
  output logic [OUT_W-1:0] lvl_o
);
  logic [NCH-1:0]   latch_q;
  logic [OUT_W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst)          latch_q <= '0;
    else if (load_en) latch_q <= data_i;
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst) lvl_q[c*CODE_W +: CODE_W] <= RAIL_V2;
        else     lvl_q[c*CODE_W +: CODE_W] <= pick_rail(latch_q[c], alt);
      end
    end
  endgenerate

  assign lvl_o = lvl_q;

  // R5
  latch_follow_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (latch_q == $past(data_i)));
  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(latch_q));
  // R7
  polarity_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lvl_q[1] == $past(alt)));
  // R8
  mid_bit_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lvl_q[0] == ($past(latch_q[0]) ~^ $past(alt))));
endmodule

// File: rtl/seg_drive_top.sv
module seg_drive_top
  import segdrv_pkg::*;
#(
  parameter int SEGS_PER_CHAIN = 20,
  parameter int SYNC_STAGES    = 2,
  localparam int NUM_CHAINS = 2,
  localparam int NUM_SEG    = NUM_CHAINS * SEGS_PER_CHAIN,
  localparam int LVL_W      = NUM_SEG * CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_clk_i,
  input  logic             latch_en_i,
  input  logic             alt_i,
  input  logic             ser_a_i,
  input  logic             ser_b_i,
  output logic             ser_a_o,
  output logic             ser_b_o,
  output logic [LVL_W-1:0] lvl_o
);
  localparam int N_ASYNC = 3 + NUM_CHAINS;

  logic [N_ASYNC-1:0] raw_in, synced;
  logic shift_lvl, latch_lvl, alt_lvl, shift_stb;
  logic [NUM_CHAINS-1:0] ser_in, ser_out;
  logic [NUM_SEG-1:0] all_stages;

  assign raw_in = {ser_b_i, ser_a_i, alt_i, latch_en_i, shift_clk_i};

  segdrv_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(raw_in), .sync_o(synced)
  );

  assign shift_lvl = synced[0];
  assign latch_lvl = synced[1];
  assign alt_lvl   = synced[2];
  assign ser_in    = synced[N_ASYNC-1:3];

  segdrv_fall_det u_fall (
    .clk(clk), .rst(rst), .level_i(shift_lvl), .fall_o(shift_stb)
  );

  generate
    for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_chain
      segdrv_chain #(.LEN(SEGS_PER_CHAIN)) u_chain (
        .clk(clk), .rst(rst), .shift_en(shift_stb), .din(ser_in[k]),
        .stages_o(all_stages[k*SEGS_PER_CHAIN +: SEGS_PER_CHAIN]),
        .dout(ser_out[k])
      );
    end
  endgenerate

  assign ser_a_o = ser_out[0];
  assign ser_b_o = ser_out[1];

  segdrv_out #(.NCH(NUM_SEG)) u_out (
    .clk(clk), .rst(rst), .load_en(latch_lvl), .alt(alt_lvl),
    .data_i(all_stages), .lvl_o(lvl_o)
  );

  // R3
  chains_lockstep_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_stb |=> ($stable(ser_a_o) && $stable(ser_b_o)));
endmodule

// File: tb/tb_seg_drive_top.sv
`timescale 1ns/1ps
module tb_seg_drive_top;
  localparam int LEN = 20;
  localparam int NS  = 2 * LEN;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, le = 1'b0, alt = 1'b0, a_in = 1'b0, b_drv = 1'b0, casc = 1'b0;
  logic b_in, a_out, b_out;
  logic [2*NS-1:0] lvl;
  int errors = 0, checks = 0;
  logic done = 1'b0;

  logic [LEN-1:0] ma = '0, mb = '0;
  logic [NS-1:0]  lat = '0;

  always #4 clk = ~clk;
  assign b_in = casc ? a_out : b_drv;

  seg_drive_top dut (
    .clk(clk), .rst(rst), .shift_clk_i(sck), .latch_en_i(le), .alt_i(alt),
    .ser_a_i(a_in), .ser_b_i(b_in), .ser_a_o(a_out), .ser_b_o(b_out), .lvl_o(lvl)
  );

  function automatic logic [2*NS-1:0] expect_bus(input logic [NS-1:0] d, input logic m);
    logic [2*NS-1:0] r;
    for (int c = 0; c < NS; c++)
      r[2*c +: 2] = d[c] ? (m ? 2'b11 : 2'b00) : (m ? 2'b10 : 2'b01);
    return r;
  endfunction

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk_bus(input string req);
    logic [2*NS-1:0] e;
    e = expect_bus(lat, alt);
    checks++;
    if (lvl !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, lvl, e);
    end
  endtask

  task automatic shift_one(input logic a, input logic b);
    logic bb;
    bb = casc ? ma[LEN-1] : b;
    a_in = a; b_drv = b; sck = 1'b1;
    repeat (6) @(posedge clk);
    sck = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    ma = {ma[LEN-2:0], a};
    mb = {mb[LEN-2:0], bb};
    chk_bit("R2 chain A serial out", a_out, ma[LEN-1]);
    chk_bit(casc ? "R4 cascade serial out" : "R3 chain B serial out", b_out, mb[LEN-1]);
    if (le) begin
      lat = {mb, ma};
      chk_bus("R5 transparent latch");
    end else begin
      chk_bus("R6 hold while latch low");
    end
  endtask

  task automatic pulse_latch(input string req);
    le = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    lat = {mb, ma};
    chk_bus(req);
    le = 1'b0;
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_alt(input logic v);
    alt = v;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk_bus("R8 alternation recode");
  endtask

  initial begin
    repeat (5) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_bit("R1 ser_a_o reset", a_out, 1'b0);
    chk_bit("R1 ser_b_o reset", b_out, 1'b0);
    chk_bus("R1 reset codes");

    // sweep of data patterns under both alternation values
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < LEN; i++) begin
        logic a, b;
        case (p)
          0: begin a = 1'b1; b = 1'b1; end
          1: begin a = 1'b0; b = 1'b0; end
          2: begin a = i[0]; b = ~i[0]; end
          default: begin a = 1'($urandom); b = 1'($urandom); end
        endcase
        shift_one(a, b);
      end
      pulse_latch("R7 code per channel");
      set_alt(~alt);
      pulse_latch("R7 code other polarity");
    end

    // R9 channel mapping: first bit lands on the highest channel of each chain
    shift_one(1'b1, 1'b0);
    for (int i = 1; i < LEN; i++) shift_one(1'b0, 1'b1);
    pulse_latch("R9 walking one mapping");

    // R5 shifting while latch held high
    le = 1'b1;
    repeat (8) @(posedge clk);
    for (int i = 0; i < 6; i++) shift_one(1'($urandom), 1'($urandom));
    le = 1'b0;
    repeat (8) @(posedge clk);

    // R4 cascade into one 40-stage chain
    casc = 1'b1;
    for (int i = 0; i < 2 * NS; i++) shift_one(1'($urandom), 1'b0);
    pulse_latch("R4 cascaded latch image");
    casc = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule